// File: doc/BRIEF.md
# Serial Command Memory Loader

The block turns a stream of bytes from a serial receiver into memory writes, so that a program image can be placed into memory before a processor starts. Bytes come in on a valid/ready interface. Every five bytes form one frame: a command byte, then four data bytes. The data bytes come most significant first and are packed into one 32-bit value. The block keeps its own store pointer and issues writes on a word-addressed memory port that has per-byte enables.

There are four commands. The first writes a whole word and then moves the pointer on by four. The second reloads the pointer. The third writes a single byte and moves the pointer on by one. The fourth ends loading. For this last command the block raises a one-cycle start pulse that carries the fixed entry address, and after that it takes no more input. A status LED lights as soon as the block reaches its polling state after reset.

Top module: `serial_cmd_loader`

## Requirements
- R1: A command takes effect only once all four of its data bytes have been accepted. Its write or start pulse is a single-cycle pulse that appears two clock edges after the edge that accepts the last data byte. Between frames nothing is written.
- R2: Command 0x00 writes the 32-bit data to word address pointer[PTR_W-1:2] with byte enables 4'b1111. It then adds 4 to the pointer.
- R3: Command 0x01 loads the pointer with the data value and produces no memory write.
- R4: Command 0x02 produces a one-cycle start_pulse. While the pulse is high, start_addr equals RUN_ADDR (default 0x00400000).
- R5: Command 0x03 writes data[7:0] with the single byte enable bit pointer[1:0] set. That byte appears on every lane of wr_data, and bit i of wr_be enables wr_data[8i+7:8i]. The command then adds 1 to the pointer.
- R6: The first data byte of a frame lands in bits 31:24 of the assembled value, and the last data byte lands in bits 7:0.
- R7: A command byte from 0x04 to 0xFF still takes its four data bytes. It has no effect on memory, the pointer or start_pulse.
- R8: After a start pulse, in_ready stays low and no write or start pulse occurs again until reset, whatever arrives on in_valid and in_data.
- R9: The pointer resets to zero. in_ready is high only while the block is waiting for a command byte or a data byte, so it is low in the cycle after each frame's last byte.
- R10: led_on is low during reset, goes high at the first clock edge after reset is released, and never falls afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte is valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept a byte this cycle |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | PTR_W-2 | Word address of the write |
| wr_data | output | 32 | Write data |
| wr_be | output | 4 | Byte enables, bit i for bits 8i+7:8i |
| start_pulse | output | 1 | One-cycle run request |
| start_addr | output | 32 | Entry address, valid with start_pulse |
| led_on | output | 1 | Status LED |

## Verification
A byte is accepted at the rising edge where in_valid and in_ready are both high. The frame then spends one cycle in an execute state, and at that cycle's edge the registered write or start outputs come up. Each result is therefore due two edges after the final byte is accepted. The bench drives inputs on falling edges and returns from the last byte at the falling edge that follows acceptance. At that point it checks that in_ready and wr_en are low, and one falling edge later it checks that wr_en is high. A monitor sampling on falling edges records every pulse, so the other scenarios compare write and start counts and the captured fields a few cycles after each frame, and they also check that nothing appears during the gaps inside a frame.

// File: rtl/loader_pkg.sv
package loader_pkg;
   localparam int LANES       = 4;
   localparam int WORD_W      = 8 * LANES;
   localparam int CNT_W       = $clog2(LANES);

   typedef enum logic [7:0] {
      CMD_WORD   = 8'h00,
      CMD_SETPTR = 8'h01,
      CMD_RUN    = 8'h02,
      CMD_BYTE   = 8'h03
   } cmd_e;

   typedef enum logic [1:0] {
      RX_CMD,
      RX_DATA,
      RX_EXEC,
      RX_HALT
   } rx_state_e;
endpackage

// File: rtl/ldr_frame_rx.sv
module ldr_frame_rx
   import loader_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic              exec_o,
   output logic [7:0]        cmd_o,
   output logic [WORD_W-1:0] word_o
);
   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [7:0]        cmd_q;
   logic [WORD_W-1:0] shift_q;
   logic              take;

   assign in_ready = (state_q == RX_CMD) || (state_q == RX_DATA);
   assign take     = in_valid && in_ready;
   assign exec_o   = (state_q == RX_EXEC);
   assign cmd_o    = cmd_q;
   assign word_o   = shift_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_CMD;
         cnt_q   <= '0;
         cmd_q   <= '0;
         shift_q <= '0;
      end else begin
         case (state_q)
            RX_CMD: if (take) begin
               cmd_q   <= in_data;
               cnt_q   <= '0;
               state_q <= RX_DATA;
            end
            RX_DATA: if (take) begin
               shift_q <= {shift_q[WORD_W-9:0], in_data};
               cnt_q   <= cnt_q + 1'b1;
               if (cnt_q == CNT_W'(LANES - 1)) state_q <= RX_EXEC;
            end
            RX_EXEC: state_q <= (cmd_q == CMD_RUN) ? RX_HALT : RX_CMD;
            default: state_q <= RX_HALT;
         endcase
      end
   end
endmodule

// File: rtl/ldr_exec.sv
module ldr_exec
   import loader_pkg::*;
#(
   parameter int          PTR_W          = 32,
   parameter logic [31:0] RUN_ADDR       = 32'h0040_0000,
   parameter bit          BYTE_REPLICATE = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_i,
   input  logic [7:0]        cmd_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              wr_en,
   output logic [PTR_W-3:0]  wr_addr,
   output logic [WORD_W-1:0] wr_data,
   output logic [LANES-1:0]  wr_be,
   output logic              start_pulse,
   output logic [31:0]       start_addr,
   output logic              led_on
);
   localparam int OFS_W = $clog2(LANES);

   logic [PTR_W-1:0]  ptr_q;
   logic [WORD_W-1:0] lane_data;
   logic [LANES-1:0]  byte_be;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (BYTE_REPLICATE) begin : g_rep
         assign lane_data[8*i +: 8] = (cmd_i == CMD_BYTE) ? word_i[7:0] : word_i[8*i +: 8];
      end else begin : g_zero
         if (i == 0) begin : g_low
            assign lane_data[7:0] = word_i[7:0];
         end else begin : g_hi
            assign lane_data[8*i +: 8] = (cmd_i == CMD_BYTE) ? 8'h00 : word_i[8*i +: 8];
         end
      end
      assign byte_be[i] = (ptr_q[OFS_W-1:0] == OFS_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q       <= '0;
         wr_en       <= 1'b0;
         wr_addr     <= '0;
         wr_data     <= '0;
         wr_be       <= '0;
         start_pulse <= 1'b0;
         start_addr  <= '0;
         led_on      <= 1'b0;
      end else begin
         led_on      <= 1'b1;
         wr_en       <= 1'b0;
         start_pulse <= 1'b0;
         if (exec_i) begin
            case (cmd_i)
               CMD_WORD: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr_q[PTR_W-1:OFS_W];
                  wr_data <= lane_data;
                  wr_be   <= '1;
                  ptr_q   <= ptr_q + PTR_W'(LANES);
               end
               CMD_SETPTR: ptr_q <= word_i[PTR_W-1:0];
               CMD_BYTE: begin
                  wr_en   <= 1'b1;
                  wr_addr <= ptr_q[PTR_W-1:OFS_W];
                  wr_data <= lane_data;
                  wr_be   <= byte_be;
                  ptr_q   <= ptr_q + 1'b1;
               end
               CMD_RUN: begin
                  start_pulse <= 1'b1;
                  start_addr  <= RUN_ADDR;
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/serial_cmd_loader.sv
module serial_cmd_loader
   import loader_pkg::*;
#(
   parameter int          PTR_W          = 32,
   parameter logic [31:0] RUN_ADDR       = 32'h0040_0000,
   parameter bit          BYTE_REPLICATE = 1'b1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   output logic             in_ready,
   output logic             wr_en,
   output logic [PTR_W-3:0] wr_addr,
   output logic [31:0]      wr_data,
   output logic [3:0]       wr_be,
   output logic             start_pulse,
   output logic [31:0]      start_addr,
   output logic             led_on
);
   if (PTR_W < 8 || PTR_W > WORD_W) begin : g_bad_ptr
      $error("serial_cmd_loader: PTR_W must lie in 8..32");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("serial_cmd_loader: port widths assume four byte lanes");
   end

   logic              exec;
   logic [7:0]        cmd;
   logic [WORD_W-1:0] word;

   ldr_frame_rx u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .in_ready (in_ready),
      .exec_o   (exec),
      .cmd_o    (cmd),
      .word_o   (word)
   );

   ldr_exec #(
      .PTR_W          (PTR_W),
      .RUN_ADDR       (RUN_ADDR),
      .BYTE_REPLICATE (BYTE_REPLICATE)
   ) u_exec (
      .clk         (clk),
      .rst_n       (rst_n),
      .exec_i      (exec),
      .cmd_i       (cmd),
      .word_i      (word),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .wr_be       (wr_be),
      .start_pulse (start_pulse),
      .start_addr  (start_addr),
      .led_on      (led_on)
   );
endmodule

// File: rtl/serial_cmd_loader_chk.sv
module serial_cmd_loader_chk #(
   parameter int          PTR_W    = 32,
   parameter logic [31:0] RUN_ADDR = 32'h0040_0000
)(
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_ready,
   input logic        wr_en,
   input logic [3:0]  wr_be,
   input logic        start_pulse,
   input logic [31:0] start_addr,
   input logic        led_on
);
   logic seen_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_start <= 1'b0;
      else if (start_pulse) seen_start <= 1'b1;
   end

   // R1
   act_after_last_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en || start_pulse) |-> $past(in_valid && in_ready, 2));

   // R1
   wr_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

   // R4
   run_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (start_addr == RUN_ADDR));

   // R4
   run_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);

   // R5
   be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($countones(wr_be) == 1 || wr_be == 4'hF));

   // R8
   halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seen_start |-> (!in_ready && !wr_en && !start_pulse));

   // R10
   led_stays_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(led_on) |-> led_on);
endmodule

bind serial_cmd_loader serial_cmd_loader_chk #(
   .PTR_W    (PTR_W),
   .RUN_ADDR (RUN_ADDR)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .wr_en       (wr_en),
   .wr_be       (wr_be),
   .start_pulse (start_pulse),
   .start_addr  (start_addr),
   .led_on      (led_on)
);

// File: tb/tb_serial_cmd_loader.sv
module tb_serial_cmd_loader;
   localparam int PTR_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [7:0]       in_data = 8'h00;
   logic             in_ready;
   logic             wr_en;
   logic [PTR_W-3:0] wr_addr;
   logic [31:0]      wr_data;
   logic [3:0]       wr_be;
   logic             start_pulse;
   logic [31:0]      start_addr;
   logic             led_on;

   int n_tests = 0;
   int n_fail  = 0;
   int wr_cnt  = 0;
   int st_cnt  = 0;
   logic [31:0] last_addr, last_data, last_st_addr;
   logic [3:0]  last_be;

   always #10 clk = ~clk;

   serial_cmd_loader dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be), .start_pulse(start_pulse), .start_addr(start_addr), .led_on(led_on)
   );

   always @(negedge clk) begin
      if (rst_n && wr_en) begin
         wr_cnt++;
         last_addr = {2'b00, wr_addr};
         last_data = wr_data;
         last_be   = wr_be;
      end
      if (rst_n && start_pulse) begin
         st_cnt++;
         last_st_addr = start_addr;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input int gap);
      repeat (gap) @(negedge clk);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_frame(input logic [7:0] cmd, input logic [31:0] d, input int gap);
      send_byte(cmd, gap);
      send_byte(d[31:24], gap);
      send_byte(d[23:16], gap);
      send_byte(d[15:8], gap);
      send_byte(d[7:0], gap);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R10 led low in reset", {31'b0, led_on}, 32'd0);
      chk("R1 no write in reset", {31'b0, wr_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 led on after reset", {31'b0, led_on}, 32'd1);
      chk("R9 ready while waiting", {31'b0, in_ready}, 32'd1);
   endtask

   task automatic t_reset_ptr();
      int w0 = wr_cnt;
      send_frame(8'h03, 32'h1122_3344, 0);
      settle();
      chk("R9 pointer reset addr", last_addr, 32'd0);
      chk("R9 pointer reset lane", {28'b0, last_be}, 32'h1);
      chk("R5 byte replicated", last_data, 32'h4444_4444);
      send_frame(8'h03, 32'h0000_0099, 0);
      settle();
      chk("R5 byte advance by one", {28'b0, last_be}, 32'h2);
      chk("R5 write count", wr_cnt - w0, 32'd2);
   endtask

   task automatic t_timing();
      int w0;
      send_frame(8'h01, 32'h0000_0100, 0);
      w0 = wr_cnt;
      send_byte(8'h00, 2);
      send_byte(8'hA1, 2);
      send_byte(8'hB2, 2);
      send_byte(8'hC3, 2);
      chk("R1 nothing before last byte", wr_cnt - w0, 32'd0);
      send_byte(8'hD4, 0);
      chk("R9 ready low in execute cycle", {31'b0, in_ready}, 32'd0);
      chk("R1 no write one edge after", {31'b0, wr_en}, 32'd0);
      @(negedge clk);
      chk("R1 write two edges after", {31'b0, wr_en}, 32'd1);
      chk("R2 word address", {2'b00, wr_addr}, 32'h40);
      chk("R2 full enables", {28'b0, wr_be}, 32'hF);
      chk("R6 msb first assembly", wr_data, 32'hA1B2_C3D4);
      @(negedge clk);
      chk("R1 write lasts one cycle", {31'b0, wr_en}, 32'd0);
   endtask

   task automatic t_word_advance();
      send_frame(8'h00, 32'hCAFE_F00D, 1);
      settle();
      chk("R2 pointer advanced by four", last_addr, 32'h41);
      chk("R2 second word data", last_data, 32'hCAFE_F00D);
   endtask

   task automatic t_setptr_byte();
      int w0 = wr_cnt;
      send_frame(8'h01, 32'h0000_0201, 0);
      settle();
      chk("R3 pointer load writes nothing", wr_cnt - w0, 32'd0);
      send_frame(8'h03, 32'hFFFF_FF5A, 0);
      settle();
      chk("R5 byte addr", last_addr, 32'h80);
      chk("R5 byte lane one", {28'b0, last_be}, 32'h2);
      chk("R5 byte data", last_data, 32'h5A5A_5A5A);
      send_frame(8'h03, 32'h0000_0077, 0);
      settle();
      chk("R5 next byte lane two", {28'b0, last_be}, 32'h4);
   endtask

   task automatic t_unknown();
      int w0 = wr_cnt;
      int s0 = st_cnt;
      send_frame(8'h04, 32'h0000_0000, 0);
      send_frame(8'hFF, 32'h1234_5678, 0);
      send_frame(8'h81, 32'h0000_0002, 0);
      settle();
      chk("R7 unknown no write", wr_cnt - w0, 32'd0);
      chk("R7 unknown no start", st_cnt - s0, 32'd0);
      send_frame(8'h03, 32'h0000_00EE, 0);
      settle();
      chk("R7 pointer untouched", {last_addr[29:0], 2'b00} | {30'b0, 2'b11 & {1'b0, last_be[3]} * 2'd3}, 32'h203);
      chk("R7 framing intact", last_data, 32'hEEEE_EEEE);
   endtask

   task automatic t_run();
      int w0, s0, bad;
      s0 = st_cnt;
      send_frame(8'h02, 32'hDEAD_BEEF, 0);
      settle();
      chk("R4 one start pulse", st_cnt - s0, 32'd1);
      chk("R4 entry address", last_st_addr, 32'h0040_0000);
      w0 = wr_cnt;
      s0 = st_cnt;
      bad = 0;
      for (int i = 0; i < 30; i++) begin
         in_valid = 1'b1;
         in_data  = (i % 5 == 0) ? 8'h00 : 8'(i * 37);
         @(negedge clk);
         if (in_ready) bad++;
      end
      in_valid = 1'b0;
      settle();
      chk("R8 ready stays low", bad, 32'd0);
      chk("R8 no writes after run", wr_cnt - w0, 32'd0);
      chk("R8 no second start", st_cnt - s0, 32'd0);
      chk("R10 led still on", {31'b0, led_on}, 32'd1);
   endtask

   initial begin
      repeat (200000) @(negedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_reset_ptr();
      t_timing();
      t_word_advance();
      t_setptr_byte();
      t_unknown();
      t_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule